// File: doc/BRIEF.md
# Addressable Control Latch with Sound Write Strobe

This block turns one byte-wide output port into eight independently settable control bits. Each write to the port updates exactly one bit of the latch. The low three bits of the written byte pick the bit, and bit 3 of the byte gives its new value. The remaining bits of the latch hold their values, so software can flip a single control line without keeping a copy of the others.

Two latch bits control neighbouring functions:

- **Bit 0** is the write enable of a sound generator. When it goes from 1 to 0, the block sends a one-clock write pulse together with the byte currently on the other output port (port A).
- **Bit 3** gates keyboard access. While bit 3 is 1, reads of port A return all ones. While bit 3 is 0, the low seven bits of the port-A output select one key of a key-status vector. A pressed key reads back as 0x00 and a released key reads back as 0xFF.

The port-B input has nothing connected, so it always reads 0xFF.

Top module: `ctl_latch_top`

## Requirements
- R1: After reset, all eight latch bits are 0 and the sound write pulse is low.
- R2: On a clock edge with the port-B write strobe high, the latch bit selected by write-data bits [2:0] takes the value of write-data bit 3. The new value is visible at the output from the cycle after that edge.
- R3: A port-B write changes at most one latch bit. The unselected bits keep their values, and write-data bits [7:4] have no effect.
- R4: With the write strobe low, the latch holds its value whatever the write data is.
- R5: A write that takes latch bit 0 from 1 to 0 raises the sound write pulse in the cycle after the edge. The sound data output then carries the port-A output byte sampled at that edge.
- R6: Every other case raises no sound pulse and leaves the sound data output unchanged. This covers writing 0 to bit 0 when it is already 0, writing 1 to bit 0, writing any other bit, and having no write at all.
- R7: The sound write pulse is high for exactly one clock.
- R8: While latch bit 3 is 1, the port-A read value is 0xFF whatever the key states are.
- R9: While latch bit 3 is 0, the port-A read value is 0x00 if the key indexed by port-A output bits [6:0] is pressed, and 0xFF otherwise. Port-A output bit 7 is ignored.
- R10: The port-B read value is always 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pb_wr | input | 1 | Port-B write strobe |
| pb_wdata | input | 8 | Port-B write byte: [2:0] bit index, [3] bit value |
| pa_out | input | 8 | Current port-A output byte |
| key_down | input | 128 | Key status, 1 = pressed |
| latch_q | output | 8 | Addressable latch bits |
| snd_wr | output | 1 | One-clock sound generator write pulse |
| snd_data | output | 8 | Byte sent with the sound write |
| pa_rd | output | 8 | Port-A read value (keyboard path) |
| pb_rd | output | 8 | Port-B read value |

## Verification
A write sampled at one rising edge shows up in `latch_q` one cycle later. The same applies to `snd_wr`/`snd_data`, and both are registered at that same edge. `pa_rd` is a combinational function of the registered latch and the live `pa_out`/`key_down`. A change to `pa_out` is therefore visible in the same cycle, but the effect of a keyboard-enable write appears only one cycle after the write. The bench changes inputs on falling edges and samples on the next falling edge, so every registered result is read exactly one edge after its cause. It also re-reads the pulse one cycle later to confirm that the pulse has dropped.

// File: rtl/ctl_latch_pkg.sv
package ctl_latch_pkg;
    localparam int unsigned LATCH_W   = 8;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned KEY_COUNT = 128;
    localparam int unsigned IDX_W     = $clog2(LATCH_W);
    localparam int unsigned KEY_IDX_W = $clog2(KEY_COUNT);

    // Roles of individual latch bits that neighbouring logic decodes
    localparam int unsigned SND_EN_BIT = 0;
    localparam int unsigned KB_OFF_BIT = 3;

    typedef struct packed {
        logic              pulse;
        logic [BYTE_W-1:0] data;
    } snd_state_t;
endpackage

// File: rtl/ctl_latch_bank.sv
module ctl_latch_bank #(
    parameter int unsigned LATCH_W = ctl_latch_pkg::LATCH_W,
    localparam int unsigned IDX_W  = $clog2(LATCH_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [IDX_W-1:0]   idx,
    input  logic               val,
    output logic [LATCH_W-1:0] bits_q
);
    logic [LATCH_W-1:0] hit;
    logic [LATCH_W-1:0] bits_d;
    logic [LATCH_W-1:0] state_q;

    // one-hot select of the addressed bit
    for (genvar i = 0; i < LATCH_W; i++) begin : g_sel
        assign hit[i] = wr && (idx == IDX_W'(i));
    end

    always_comb begin
        bits_d = state_q;
        for (int i = 0; i < LATCH_W; i++) begin
            if (hit[i]) bits_d[i] = val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= bits_d;
    end

    assign bits_q = state_q;
endmodule

// File: rtl/ctl_snd_strobe.sv
module ctl_snd_strobe
    import ctl_latch_pkg::*;
#(
    parameter int unsigned LATCH_W = ctl_latch_pkg::LATCH_W,
    parameter int unsigned BYTE_W  = ctl_latch_pkg::BYTE_W,
    localparam int unsigned IDX_W  = $clog2(LATCH_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic              val,
    input  logic              en_q,
    input  logic [BYTE_W-1:0] pa_byte,
    output logic              pulse,
    output logic [BYTE_W-1:0] data
);
    typedef struct packed {
        logic              pulse;
        logic [BYTE_W-1:0] data;
    } st_t;

    st_t st_d, st_q;
    logic falls;

    always_comb begin
        // falling edge of the enable bit as a result of this write
        falls    = wr && (idx == IDX_W'(SND_EN_BIT)) && !val && en_q;
        st_d       = st_q;
        st_d.pulse = falls;
        if (falls) st_d.data = pa_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;
    assign data  = st_q.data;
endmodule

// File: rtl/ctl_key_reader.sv
module ctl_key_reader #(
    parameter int unsigned KEY_COUNT = ctl_latch_pkg::KEY_COUNT,
    parameter int unsigned BYTE_W    = ctl_latch_pkg::BYTE_W,
    localparam int unsigned KEY_IDX_W = $clog2(KEY_COUNT)
) (
    input  logic                 kb_off,
    input  logic [BYTE_W-1:0]    pa_byte,
    input  logic [KEY_COUNT-1:0] key_down,
    output logic [BYTE_W-1:0]    rd
);
    logic [KEY_IDX_W-1:0] sel;
    logic                 pressed;

    always_comb begin
        sel     = pa_byte[KEY_IDX_W-1:0];
        pressed = key_down[sel];
        if (kb_off || !pressed) rd = '1;
        else                    rd = '0;
    end
endmodule

// File: rtl/ctl_latch_top.sv
module ctl_latch_top
    import ctl_latch_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pb_wr,
    input  logic [BYTE_W-1:0]    pb_wdata,
    input  logic [BYTE_W-1:0]    pa_out,
    input  logic [KEY_COUNT-1:0] key_down,
    output logic [LATCH_W-1:0]   latch_q,
    output logic                 snd_wr,
    output logic [BYTE_W-1:0]    snd_data,
    output logic [BYTE_W-1:0]    pa_rd,
    output logic [BYTE_W-1:0]    pb_rd
);
    logic [IDX_W-1:0] wr_idx;
    logic             wr_val;

    assign wr_idx = pb_wdata[IDX_W-1:0];
    assign wr_val = pb_wdata[IDX_W];

    ctl_latch_bank #(.LATCH_W(LATCH_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (pb_wr),
        .idx    (wr_idx),
        .val    (wr_val),
        .bits_q (latch_q)
    );

    ctl_snd_strobe #(.LATCH_W(LATCH_W), .BYTE_W(BYTE_W)) u_snd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (pb_wr),
        .idx     (wr_idx),
        .val     (wr_val),
        .en_q    (latch_q[SND_EN_BIT]),
        .pa_byte (pa_out),
        .pulse   (snd_wr),
        .data    (snd_data)
    );

    ctl_key_reader #(.KEY_COUNT(KEY_COUNT), .BYTE_W(BYTE_W)) u_keys (
        .kb_off   (latch_q[KB_OFF_BIT]),
        .pa_byte  (pa_out),
        .key_down (key_down),
        .rd       (pa_rd)
    );

    // nothing is wired to the port-B inputs
    assign pb_rd = '1;
endmodule

// File: rtl/ctl_latch_chk.sv
module ctl_latch_chk
    import ctl_latch_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pb_wr,
    input logic [BYTE_W-1:0]    pb_wdata,
    input logic [BYTE_W-1:0]    pa_out,
    input logic [LATCH_W-1:0]   latch_q,
    input logic                 snd_wr,
    input logic [BYTE_W-1:0]    snd_data,
    input logic [BYTE_W-1:0]    pa_rd,
    input logic [BYTE_W-1:0]    pb_rd
);
    // R2
    bit_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pb_wr |=> latch_q[$past(pb_wdata[IDX_W-1:0])] == $past(pb_wdata[IDX_W]));

    // R3
    single_bit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pb_wr |=> $countones(latch_q ^ $past(latch_q)) <= 1);

    // R4
    hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pb_wr |=> $stable(latch_q));

    // R5
    snd_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_wr && pb_wdata[IDX_W:0] == '0 && latch_q[SND_EN_BIT])
        |=> (snd_wr && snd_data == $past(pa_out)));

    // R6
    snd_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snd_wr |-> $fell(latch_q[SND_EN_BIT]));

    // R6
    snd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snd_wr |-> $stable(snd_data));

    // R7
    snd_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snd_wr |=> !snd_wr);

    // R8
    kb_off_reads_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_q[KB_OFF_BIT] |-> pa_rd == '1);

    // R10
    pb_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pb_rd == '1);
endmodule

bind ctl_latch_top ctl_latch_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pb_wr    (pb_wr),
    .pb_wdata (pb_wdata),
    .pa_out   (pa_out),
    .latch_q  (latch_q),
    .snd_wr   (snd_wr),
    .snd_data (snd_data),
    .pa_rd    (pa_rd),
    .pb_rd    (pb_rd)
);

// File: tb/tb_ctl_latch_top.sv
module tb_ctl_latch_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 11;

    // {pb_wdata, pa_out, exp_latch, exp_snd_wr(8b), exp_snd_data}
    localparam logic [39:0] VEC [NVEC] = '{
        {8'h08, 8'h11, 8'h01, 8'h00, 8'h00},
        {8'h00, 8'h22, 8'h00, 8'h01, 8'h22},
        {8'h00, 8'h33, 8'h00, 8'h00, 8'h22},
        {8'h0B, 8'h44, 8'h08, 8'h00, 8'h22},
        {8'hFE, 8'h45, 8'h48, 8'h00, 8'h22},
        {8'h09, 8'h46, 8'h4A, 8'h00, 8'h22},
        {8'h08, 8'h47, 8'h4B, 8'h00, 8'h22},
        {8'h0F, 8'h48, 8'hCB, 8'h00, 8'h22},
        {8'h03, 8'h49, 8'hC3, 8'h00, 8'h22},
        {8'h70, 8'h5A, 8'hC2, 8'h01, 8'h5A},
        {8'h06, 8'h5B, 8'h82, 8'h00, 8'h5A}
    };

    logic         clk = 0;
    logic         rst_n = 0;
    logic         pb_wr = 0;
    logic [7:0]   pb_wdata = 0;
    logic [7:0]   pa_out = 0;
    logic [127:0] key_down = 0;
    logic [7:0]   latch_q, snd_data, pa_rd, pb_rd;
    logic         snd_wr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_latch_top dut (
        .clk(clk), .rst_n(rst_n), .pb_wr(pb_wr), .pb_wdata(pb_wdata),
        .pa_out(pa_out), .key_down(key_down), .latch_q(latch_q),
        .snd_wr(snd_wr), .snd_data(snd_data), .pa_rd(pa_rd), .pb_rd(pb_rd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive on a falling edge, capture at the rising edge, return at the next falling edge
    task automatic write_pb(input logic [7:0] wd, input logic [7:0] pa);
        pb_wr    = 1;
        pb_wdata = wd;
        pa_out   = pa;
        @(negedge clk);
        pb_wr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        key_down[9]   = 1;
        key_down[7]   = 1;
        key_down[127] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 latch", latch_q, 8'h00);
        check("R1 snd_wr", snd_wr, 1'b0);
        check("R10 pb_rd", pb_rd, 8'hFF);
        check("R9 key0 released", pa_rd, 8'hFF);

        for (int i = 0; i < NVEC; i++) begin
            write_pb(VEC[i][39:32], VEC[i][31:24]);
            check($sformatf("R2/R3 latch vec%0d", i), latch_q, VEC[i][23:16]);
            check($sformatf("R5/R6 snd_wr vec%0d", i), snd_wr, VEC[i][8]);
            check($sformatf("R5/R6 snd_data vec%0d", i), snd_data, VEC[i][7:0]);
            if (VEC[i][8]) begin
                @(negedge clk);
                check("R7 pulse dropped", snd_wr, 1'b0);
            end
        end

        // R4: strobe low with data that would clear bit 1 and bit 7
        pb_wdata = 8'h01;
        @(negedge clk);
        pb_wdata = 8'h07;
        @(negedge clk);
        check("R4 latch held", latch_q, 8'h82);
        check("R6 no pulse without write", snd_wr, 1'b0);

        // R9 keyboard path, latch bit 3 is 0
        pa_out = 8'h09; #1;
        check("R9 key9 pressed", pa_rd, 8'h00);
        pa_out = 8'h89; #1;
        check("R9 bit7 ignored", pa_rd, 8'h00);
        pa_out = 8'h08; #1;
        check("R9 key8 released", pa_rd, 8'hFF);
        pa_out = 8'h7F; #1;
        check("R9 key127 pressed", pa_rd, 8'h00);
        @(negedge clk);

        // R8: set bit 3, keyboard gated off
        write_pb(8'h0B, 8'h09);
        check("R8 latch bit3 set", latch_q, 8'h8A);
        check("R8 gated read", pa_rd, 8'hFF);
        pa_out = 8'h07; #1;
        check("R8 gated key7", pa_rd, 8'hFF);
        check("R10 pb_rd", pb_rd, 8'hFF);

        // R6: writing 1 to bit 0 gives no pulse, then falling edge gives pulse
        write_pb(8'h08, 8'hA5);
        check("R6 rise no pulse", snd_wr, 1'b0);
        check("R6 data kept", snd_data, 8'h5A);
        write_pb(8'h00, 8'hC3);
        check("R5 fall pulse", snd_wr, 1'b1);
        check("R5 fall data", snd_data, 8'hC3);
        @(negedge clk);
        check("R7 single clock", snd_wr, 1'b0);

        // R1 again: reset mid-run
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check("R1 re-reset latch", latch_q, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule